// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one display pipe. It holds a horizontal and a vertical position counter and drives horizontal sync, vertical sync, a display-enable strobe and the current pixel coordinates. The raster is set up by four 32-bit packed configuration words. Horizontal quantities are counted in 8-pixel character cells. The total and the start fields are stored with small fixed offsets. Each sync pulse has its own polarity bit.

Software writes the configuration words through a simple write port at any time. The block keeps each written value in a shadow copy, and the raster uses the new values only from the first pixel of the following frame. A two-bit power control can remove either sync pulse and always blanks the display when the pipe is not fully on. A sticky vertical-sync status flag is raised once per frame. It stays high until a controller acknowledges it.

Top module: `crtc_timing_gen`

## Requirements
- R1: Horizontal span word (selector 0): bits 9:0 hold total/8-1 and bits 25:16 hold active width/8-1. `px_x` counts 0..total-1, returns to 0 after total-1, and `de` is high only while `px_x` < active width (and R3/R7 allow it).
- R2: Horizontal pulse word (selector 1): bits 12:0 hold sync start minus 8 pixels and bits 21:16 hold the width in 8-pixel units. The pulse covers pixels [start, start+8*width). A width field of 0 acts as 1, which keeps the width in 1..63 units.
- R3: Vertical span word (selector 2): bits 15:0 hold total lines-1 and bits 27:16 hold active lines-1. `px_y` advances when `px_x` wraps, returns to 0 after total-1, and `de` is low on lines >= active lines.
- R4: Vertical pulse word (selector 3): bits 11:0 hold sync start line-1 and bits 20:16 hold the width in lines. A width of 0 acts as 1, which keeps the width in 1..31 lines.
- R5: Bit 23 of each pulse word, when set, makes that sync active-low. When clear, the sync is active-high.
- R6: `power_mode` 0 = on, 1 = standby (hsync removed), 2 = suspend (vsync removed), 3 = off (both removed). Bit 0 removes hsync and bit 1 removes vsync.
- R7: A removed sync sits at its inactive level. `de` is low whenever `power_mode` is not 0.
- R8: `vsync_irq` rises one cycle after the counters reach pixel 0 of the sync start line. It stays high until a cycle with `irq_ack` high. A new set in that same cycle wins over the acknowledge.
- R9: A configuration write goes to a shadow copy. The raster uses it only after the last pixel of the current frame. A write in the frame's last cycle waits one more frame.
- R10: Reset (synchronous, active high) sets the counters to 0, clears `vsync_irq`, and loads the default parameter words into both the shadow and the active copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for a configuration word |
| cfg_sel | input | 2 | Word selector (0..3, see R1-R4 words) |
| cfg_data | input | 32 | Configuration word to write |
| power_mode | input | 2 | Power state (R6) |
| irq_ack | input | 1 | Clears the sticky vsync flag |
| hsync | output | 1 | Horizontal sync, polarity per R5 |
| vsync | output | 1 | Vertical sync, polarity per R5 |
| de | output | 1 | Display enable |
| px_x | output | 14 | Current pixel within the line |
| px_y | output | 17 | Current line within the frame |
| vsync_irq | output | 1 | Sticky vertical-sync status |

## Verification
On every cycle the assertions check the following: the pixel counter steps by one or wraps to zero, the line counter holds within a line, a removed sync sits at its inactive level and display-enable stays low outside the on state, the status flag stays set until acknowledged and clears after an acknowledge, and the active configuration stays constant except at a frame boundary. Other behaviour can only be shown by the bench's scenarios: the minus-one and minus-eight field offsets, the 8-pixel width scaling, the zero-width clamps, the polarity inversion, and a mid-frame write that takes effect exactly one frame later. For these the bench runs a cycle-accurate reference model against the design over every cycle and adds checks at chosen coordinates.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int CFG_W   = 32;
    localparam int NREG    = 4;
    localparam int SEL_W   = $clog2(NREG);
    localparam int HCW     = 14;
    localparam int VCW     = 17;
    localparam int POL_BIT = 23;

    typedef enum logic [SEL_W-1:0] {
        SEL_H_SPAN  = 2'd0,
        SEL_H_PULSE = 2'd1,
        SEL_V_SPAN  = 2'd2,
        SEL_V_PULSE = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        PWR_ON      = 2'd0,
        PWR_STANDBY = 2'd1,
        PWR_SUSPEND = 2'd2,
        PWR_OFF     = 2'd3
    } pwr_e;

    typedef struct packed {
        logic [HCW-1:0] h_total;
        logic [HCW-1:0] h_act;
        logic [HCW-1:0] hs_start;
        logic [HCW-1:0] hs_len;
        logic           hs_low;
        logic [VCW-1:0] v_total;
        logic [VCW-1:0] v_act;
        logic [VCW-1:0] vs_start;
        logic [VCW-1:0] vs_len;
        logic           vs_low;
    } raster_t;

    function automatic logic [5:0] clamp_h_units(input logic [5:0] w);
        return (w == 6'd0) ? 6'd1 : w;
    endfunction

    function automatic logic [4:0] clamp_v_lines(input logic [4:0] w);
        return (w == 5'd0) ? 5'd1 : w;
    endfunction

    function automatic raster_t unpack_cfg(
        input logic [CFG_W-1:0] h_span,
        input logic [CFG_W-1:0] h_pulse,
        input logic [CFG_W-1:0] v_span,
        input logic [CFG_W-1:0] v_pulse
    );
        raster_t r;
        r.h_total  = HCW'({h_span[9:0], 3'b000}) + HCW'(8);
        r.h_act    = HCW'({h_span[25:16], 3'b000}) + HCW'(8);
        r.hs_start = HCW'(h_pulse[12:0]) + HCW'(8);
        r.hs_len   = HCW'({clamp_h_units(h_pulse[21:16]), 3'b000});
        r.hs_low   = h_pulse[POL_BIT];
        r.v_total  = VCW'(v_span[15:0]) + VCW'(1);
        r.v_act    = VCW'(v_span[27:16]) + VCW'(1);
        r.vs_start = VCW'(v_pulse[11:0]) + VCW'(1);
        r.vs_len   = VCW'(clamp_v_lines(v_pulse[20:16]));
        r.vs_low   = v_pulse[POL_BIT];
        return r;
    endfunction

endpackage

// File: rtl/crtc_cfg_bank.sv
module crtc_cfg_bank
    import crtc_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_H_SPAN  = 32'h0001_0003,
    parameter logic [CFG_W-1:0] DEF_H_PULSE = 32'h0001_000C,
    parameter logic [CFG_W-1:0] DEF_V_SPAN  = 32'h0003_0005,
    parameter logic [CFG_W-1:0] DEF_V_PULSE = 32'h0001_0003
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [CFG_W-1:0] wdata,
    input  logic             frame_end,
    output raster_t          act
);
    localparam logic [NREG-1:0][CFG_W-1:0] DEFS =
        {DEF_V_PULSE, DEF_V_SPAN, DEF_H_PULSE, DEF_H_SPAN};

    logic [CFG_W-1:0] shadow [NREG];
    logic [CFG_W-1:0] live   [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[i] <= DEFS[i];
                live[i]   <= DEFS[i];
            end else begin
                if (frame_end)
                    live[i] <= shadow[i];
                if (wr && sel == SEL_W'(i))
                    shadow[i] <= wdata;
            end
        end
    end

    always_comb begin
        act = unpack_cfg(live[SEL_H_SPAN], live[SEL_H_PULSE],
                         live[SEL_V_SPAN], live[SEL_V_PULSE]);
    end
endmodule

// File: rtl/crtc_scan.sv
module crtc_scan
    import crtc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  raster_t        act,
    output logic [HCW-1:0] x,
    output logic [VCW-1:0] y,
    output logic           frame_end
);
    logic line_end;
    logic last_line;

    always_comb begin
        line_end  = (x >= act.h_total - HCW'(1));
        last_line = (y >= act.v_total - VCW'(1));
        frame_end = line_end && last_line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0;
            y <= '0;
        end else if (line_end) begin
            x <= '0;
            y <= last_line ? '0 : y + VCW'(1);
        end else begin
            x <= x + HCW'(1);
        end
    end
endmodule

// File: rtl/crtc_sync_out.sv
module crtc_sync_out
    import crtc_pkg::*;
(
    input  raster_t        act,
    input  logic [HCW-1:0] x,
    input  logic [VCW-1:0] y,
    input  logic [1:0]     pmode,
    output logic           hsync,
    output logic           vsync,
    output logic           de
);
    logic [HCW:0] hs_end;
    logic [VCW:0] vs_end;
    logic         hs_on;
    logic         vs_on;
    logic         h_cut;
    logic         v_cut;

    always_comb begin
        hs_end = {1'b0, act.hs_start} + {1'b0, act.hs_len};
        vs_end = {1'b0, act.vs_start} + {1'b0, act.vs_len};
        hs_on  = (x >= act.hs_start) && ({1'b0, x} < hs_end);
        vs_on  = (y >= act.vs_start) && ({1'b0, y} < vs_end);
        h_cut  = (pmode == PWR_STANDBY) || (pmode == PWR_OFF);
        v_cut  = (pmode == PWR_SUSPEND) || (pmode == PWR_OFF);
        hsync  = (hs_on && !h_cut) ^ act.hs_low;
        vsync  = (vs_on && !v_cut) ^ act.vs_low;
        de     = (pmode == PWR_ON) && (x < act.h_act) && (y < act.v_act);
    end
endmodule

// File: rtl/crtc_vs_flag.sv
module crtc_vs_flag
    import crtc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  raster_t        act,
    input  logic [HCW-1:0] x,
    input  logic [VCW-1:0] y,
    input  logic           ack,
    output logic           flag
);
    logic hit;

    always_comb hit = (x == '0) && (y == act.vs_start);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (ack)
            flag <= 1'b0;
    end
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_H_SPAN  = 32'h0001_0003,
    parameter logic [CFG_W-1:0] DEF_H_PULSE = 32'h0001_000C,
    parameter logic [CFG_W-1:0] DEF_V_SPAN  = 32'h0003_0005,
    parameter logic [CFG_W-1:0] DEF_V_PULSE = 32'h0001_0003
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [1:0]       power_mode,
    input  logic             irq_ack,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [HCW-1:0]   px_x,
    output logic [VCW-1:0]   px_y,
    output logic             vsync_irq
);
    raster_t act_tim;
    logic    frame_end;

    crtc_cfg_bank #(
        .DEF_H_SPAN (DEF_H_SPAN),
        .DEF_H_PULSE(DEF_H_PULSE),
        .DEF_V_SPAN (DEF_V_SPAN),
        .DEF_V_PULSE(DEF_V_PULSE)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .sel      (cfg_sel),
        .wdata    (cfg_data),
        .frame_end(frame_end),
        .act      (act_tim)
    );

    crtc_scan u_scan (
        .clk      (clk),
        .rst      (rst),
        .act      (act_tim),
        .x        (px_x),
        .y        (px_y),
        .frame_end(frame_end)
    );

    crtc_sync_out u_sync (
        .act  (act_tim),
        .x    (px_x),
        .y    (px_y),
        .pmode(power_mode),
        .hsync(hsync),
        .vsync(vsync),
        .de   (de)
    );

    crtc_vs_flag u_flag (
        .clk (clk),
        .rst (rst),
        .act (act_tim),
        .x   (px_x),
        .y   (px_y),
        .ack (irq_ack),
        .flag(vsync_irq)
    );
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [HCW-1:0] px_x,
    input logic [VCW-1:0] px_y,
    input logic           hsync,
    input logic           vsync,
    input logic           de,
    input logic [1:0]     power_mode,
    input logic           irq_ack,
    input logic           vsync_irq,
    input raster_t        act,
    input logic           frame_end
);
    p_x_step_r1: assert property (@(posedge clk) disable iff (rst)
        (px_x == '0) || (px_x == $past(px_x) + HCW'(1)));

    p_y_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (px_x != '0) |-> $stable(px_y));

    p_hs_gate_r6: assert property (@(posedge clk) disable iff (rst)
        power_mode[0] |-> (hsync == act.hs_low));

    p_vs_gate_r6: assert property (@(posedge clk) disable iff (rst)
        power_mode[1] |-> (vsync == act.vs_low));

    p_de_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (power_mode != 2'd0) |-> !de);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (vsync_irq && !irq_ack) |=> vsync_irq);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (vsync_irq && irq_ack && !((px_x == '0) && (px_y == act.vs_start)))
        |=> !vsync_irq);

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(act));
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .px_x      (px_x),
    .px_y      (px_y),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .power_mode(power_mode),
    .irq_ack   (irq_ack),
    .vsync_irq (vsync_irq),
    .act       (act_tim),
    .frame_end (frame_end)
);

// File: tb/crtc_timing_gen_test.sv
module crtc_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_data = 32'd0;
    logic [1:0]  power_mode = 2'd0;
    logic        irq_ack = 1'b0;
    logic        hsync, vsync, de, vsync_irq;
    logic [13:0] px_x;
    logic [16:0] px_y;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    crtc_timing_gen uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .power_mode(power_mode), .irq_ack(irq_ack),
        .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
        .vsync_irq(vsync_irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d at t=%0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model and scoreboard ----------------
    typedef struct {
        int x; int y; bit hs; bit vs; bit de; bit irq;
    } exp_t;

    exp_t exp_q[$];

    localparam logic [31:0] D0 = 32'h0001_0003;
    localparam logic [31:0] D1 = 32'h0001_000C;
    localparam logic [31:0] D2 = 32'h0003_0005;
    localparam logic [31:0] D3 = 32'h0001_0003;

    int          mx = 0, my = 0;
    bit          mirq = 0;
    logic [31:0] mlive [4];
    logic [31:0] mshad [4];

    function automatic int f_htot(logic [31:0] w); return (int'(w[9:0]) + 1) * 8; endfunction
    function automatic int f_hact(logic [31:0] w); return (int'(w[25:16]) + 1) * 8; endfunction
    function automatic int f_hss (logic [31:0] w); return int'(w[12:0]) + 8; endfunction
    function automatic int f_hsw (logic [31:0] w);
        return (w[21:16] == 0) ? 8 : int'(w[21:16]) * 8;
    endfunction
    function automatic int f_vtot(logic [31:0] w); return int'(w[15:0]) + 1; endfunction
    function automatic int f_vact(logic [31:0] w); return int'(w[27:16]) + 1; endfunction
    function automatic int f_vss (logic [31:0] w); return int'(w[11:0]) + 1; endfunction
    function automatic int f_vsw (logic [31:0] w);
        return (w[20:16] == 0) ? 1 : int'(w[20:16]);
    endfunction

    always @(negedge clk) begin
        exp_t e;
        bit   hon, von, fe, nirq;
        if (rst) begin
            mx = 0; my = 0; mirq = 0;
            mlive[0] = D0; mlive[1] = D1; mlive[2] = D2; mlive[3] = D3;
            mshad = mlive;
        end else begin
            hon = (mx >= f_hss(mlive[1])) && (mx < f_hss(mlive[1]) + f_hsw(mlive[1]))
                  && !power_mode[0];
            von = (my >= f_vss(mlive[3])) && (my < f_vss(mlive[3]) + f_vsw(mlive[3]))
                  && !power_mode[1];
            e.x   = mx;
            e.y   = my;
            e.hs  = hon ^ mlive[1][23];
            e.vs  = von ^ mlive[3][23];
            e.de  = (power_mode == 2'd0) && (mx < f_hact(mlive[0])) && (my < f_vact(mlive[2]));
            e.irq = mirq;
            exp_q.push_back(e);
            // advance to the state after the coming edge
            fe   = (mx == f_htot(mlive[0]) - 1) && (my == f_vtot(mlive[2]) - 1);
            nirq = (mx == 0 && my == f_vss(mlive[3])) ? 1'b1 : (irq_ack ? 1'b0 : mirq);
            if (mx == f_htot(mlive[0]) - 1) begin
                mx = 0;
                my = (my == f_vtot(mlive[2]) - 1) ? 0 : my + 1;
            end else begin
                mx = mx + 1;
            end
            mirq = nirq;
            if (fe) mlive = mshad;
            if (cfg_wr) mshad[cfg_sel] = cfg_data;
        end
    end

    always @(negedge clk) begin
        exp_t e;
        #1;
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check("R1 px_x", int'(px_x), e.x);
            check("R3 px_y", int'(px_y), e.y);
            check("R2 hsync", int'(hsync), int'(e.hs));
            check("R4 vsync", int'(vsync), int'(e.vs));
            check("R7 de", int'(de), int'(e.de));
            check("R8 vsync_irq", int'(vsync_irq), int'(e.irq));
        end
    end

    // ---------------- driver helpers ----------------
    task automatic write_cfg(input logic [1:0] sel, input logic [31:0] data);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = data;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic set_power(input logic [1:0] m);
        @(posedge clk); #1;
        power_mode = m;
    endtask

    task automatic pulse_ack();
        @(posedge clk); #1;
        irq_ack = 1'b1;
        @(posedge clk); #1;
        irq_ack = 1'b0;
    endtask

    task automatic wait_xy(input int x, input int y);
        do @(negedge clk); while (!(int'(px_x) == x && int'(px_y) == y));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 px_x after reset", int'(px_x), 0);
        check("R10 px_y after reset", int'(px_y), 0);
        check("R10 vsync_irq after reset", int'(vsync_irq), 0);
        check("R10 de at origin", int'(de), 1);

        // R8: flag rises one pixel into the sync start line, then sticks
        wait_xy(1, 4);
        check("R8 flag set", int'(vsync_irq), 1);
        wait_xy(0, 0);
        check("R8 flag sticky", int'(vsync_irq), 1);
        pulse_ack();
        @(negedge clk);
        check("R8 flag cleared by ack", int'(vsync_irq), 0);

        // R6 / R7: power states
        set_power(2'd1);
        wait_xy(22, 0);
        check("R6 standby hsync removed", int'(hsync), 0);
        wait_xy(2, 1);
        check("R7 standby de low", int'(de), 0);
        wait_xy(0, 4);
        check("R6 standby vsync kept", int'(vsync), 1);
        set_power(2'd2);
        wait_xy(22, 1);
        check("R6 suspend hsync kept", int'(hsync), 1);
        wait_xy(0, 4);
        check("R6 suspend vsync removed", int'(vsync), 0);
        set_power(2'd3);
        wait_xy(22, 0);
        check("R6 off hsync removed", int'(hsync), 0);
        wait_xy(0, 4);
        check("R6 off vsync removed", int'(vsync), 0);
        set_power(2'd0);

        // R5: active-low hsync
        write_cfg(2'd1, 32'h0081_000C);
        wait_xy(0, 0);
        wait_xy(5, 0);
        check("R5 low-polarity idle level", int'(hsync), 1);
        wait_xy(22, 0);
        check("R5 low-polarity pulse", int'(hsync), 0);

        // R9 + R2: mid-frame write waits for the next frame; width 0 clamps to 1 unit
        wait_xy(0, 2);
        write_cfg(2'd1, 32'h0000_0000);
        wait_xy(22, 3);
        check("R9 old pulse still in use", int'(hsync), 0);
        wait_xy(10, 0);
        check("R2 new start at 8", int'(hsync), 1);
        wait_xy(16, 0);
        check("R2 zero width acts as 8 pixels", int'(hsync), 0);

        // R4: vertical pulse at line 2, width 0 -> one line
        write_cfg(2'd3, 32'h0000_0001);
        wait_xy(0, 0);
        wait_xy(0, 2);
        check("R4 vsync on start line", int'(vsync), 1);
        wait_xy(0, 3);
        check("R4 zero width acts as one line", int'(vsync), 0);

        // R1 / R3: new raster size 48 x 8, active 24 x 5
        wait_xy(0, 1);
        write_cfg(2'd0, 32'h0002_0005);
        write_cfg(2'd2, 32'h0004_0007);
        wait_xy(0, 0);
        wait_xy(47, 0);
        check("R1 reaches total-1", int'(px_x), 47);
        @(negedge clk);
        check("R1 wraps after total-1", int'(px_x), 0);
        check("R3 line advances on wrap", int'(px_y), 1);
        wait_xy(23, 4);
        check("R1 de inside active width", int'(de), 1);
        @(negedge clk);
        check("R1 de past active width", int'(de), 0);
        wait_xy(0, 5);
        check("R3 de off past active lines", int'(de), 0);
        wait_xy(0, 7);
        wait_xy(0, 0);
        check("R3 wraps after total-1", int'(px_y), 0);

        repeat (50) @(negedge clk);
        finish_run();
    end

endmodule